// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This block keeps the event flags of a serial bus controller and the mask that decides which of them may interrupt the processor. The data path pulses per-flag set and clear inputs. Software reaches the block through a small word-indexed register port. The block drives one level interrupt line and two DMA request lines, one for receive and one for transmit. In the older register model, it also offers a vector register. Reading that register returns the lowest-numbered pending enabled source and acknowledges it in the same access.

A single bit parameter, `REV_NEWER`, picks the register model. The older model has a 5-bit enable mask, a read-only status register and the acknowledging vector register. The newer model has a 6-bit mask and write-one-to-clear status. In the newer model the vector offset is not decoded, and a test write can force the six low flags high. In both models, turning on a DMA channel removes the interrupt enable of the matching ready flag.

Register offsets (word index on `reg_sel`): 0 enable mask, 1 status, 2 vector, 3 DMA configuration, 4 test, 5 to 7 unused. Read data is registered: it appears on `reg_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `intr_status_unit`

## Requirements
- R1: `irq` is high exactly when status bits 5:0 ANDed with the enable mask is nonzero.
- R2: In the older model, a read of offset 2 returns the 1-based index of the lowest set bit of (status[5:0] AND enable), or 0 when there is none. The same access clears that one status bit and leaves the other bits alone.
- R3: `rx_dreq` equals status bit 3 (receive ready) while DMA configuration bit 15 is set, and is low otherwise. `tx_dreq` equals status bit 4 (transmit ready) while configuration bit 7 is set, and is low otherwise.
- R4: A write to offset 3 keeps only data bits 15 and 7. Bit 15 set clears enable bit 3, and bit 7 set clears enable bit 4.
- R5: The enable mask holds bits 5:0 in the newer model and bits 4:0 in the older model. Bit 5 reads as 0 in the older model and never raises `irq` there.
- R6: In the newer model, a write to offset 1 clears each status bit whose data bit is set under mask 0x0027, so bits 3 and 4 and all others are kept. In the older model, status writes have no effect.
- R7: In the newer model, any access to offset 2 is invalid: a read returns 0, `reg_err` pulses, and the status is not changed.
- R8: Bit 12 of a status read is the live `bus_busy` input, and bit 12 of `flag_set` is ignored.
- R9: A write to offset 4 stores data ANDed with 0xF80F, and reads return the stored value. In the newer model only, data bit 11 set also forces status bits 5:0 to one.
- R10: When a set pulse and a clearing action hit the same status bit in one cycle, the bit ends up set.
- R11: An access to offsets 5 to 7 changes no state, returns 0 when read, and gives a one-cycle `reg_err` pulse. `reg_err` is never high in the cycle after a cycle with no access.
- R12: After reset, all flags, the mask, the DMA configuration, the test value, `irq` and both DMA requests are zero.
- R13: A `flag_clr` bit clears the matching status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register word index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| reg_err | output | 1 | One-cycle invalid-access pulse |
| flag_set | input | 16 | Per-flag set pulses from the data path |
| flag_clr | input | 16 | Per-flag clear pulses from the data path |
| bus_busy | input | 1 | Live bus-busy indication |
| irq | output | 1 | Interrupt request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_dreq | output | 1 | Transmit DMA request |

## Verification
Two instances, one per register model, receive the same stimulus, so every pattern also shows where the models differ. The patterns are as follows:
- Lone set pulses, a set coinciding with a clear, and flags outside the mask tell masking apart from priority.
- Two pending sources read out through the vector one after another check the lowest-first order and the single-bit acknowledge.
- An all-ones status write separates the write-one-to-clear bits from the protected ready flags.
- All-ones DMA and test writes check the field filtering and the forced flags.
- Invalid offsets and the bus-busy bit are checked against state read back through the register port.

// File: rtl/isv_pkg.sv
package isv_pkg;

    localparam int DW     = 16;
    localparam int NSRC   = 6;
    localparam int AW     = 3;
    localparam int VEC_W  = $clog2(NSRC + 1);

    localparam int BUSY_BIT       = 12;
    localparam int RX_RDY_BIT     = 3;
    localparam int TX_RDY_BIT     = 4;
    localparam int DMA_RX_EN_BIT  = 15;
    localparam int DMA_TX_EN_BIT  = 7;
    localparam int TEST_FORCE_BIT = 11;

    localparam logic [DW-1:0] W1C_MASK   = 16'h0027;
    localparam logic [DW-1:0] STAT_STORE = 16'hEFFF;
    localparam logic [DW-1:0] DMA_KEEP   = 16'h8080;
    localparam logic [DW-1:0] TEST_KEEP  = 16'hF80F;
    localparam logic [DW-1:0] FORCE_SET  = 16'h003F;
    localparam logic [DW-1:0] RDY_BITS   = 16'h0018;

    typedef enum logic [AW-1:0] {
        OFF_ENABLE = 3'd0,
        OFF_STATUS = 3'd1,
        OFF_VECTOR = 3'd2,
        OFF_DMACFG = 3'd3,
        OFF_TEST   = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic en_wr;
        logic stat_wr;
        logic dma_wr;
        logic test_wr;
        logic en_rd;
        logic stat_rd;
        logic vec_rd;
        logic dma_rd;
        logic test_rd;
        logic bad;
    } acc_t;

    // 1-based index of the lowest set bit, 0 when none is set
    function automatic logic [VEC_W-1:0] lowest_pending(input logic [NSRC-1:0] v);
        logic [VEC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = VEC_W'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/isv_decode.sv
module isv_decode
    import isv_pkg::*;
#(
    parameter bit REV_NEWER = 1'b1
) (
    input  logic [AW-1:0] sel,
    input  logic          rd,
    input  logic          wr,
    output acc_t          acc
);

    always_comb begin
        acc = '0;
        case (sel)
            OFF_ENABLE: begin
                acc.en_wr = wr;
                acc.en_rd = rd;
            end
            OFF_STATUS: begin
                acc.stat_rd = rd;
                acc.stat_wr = wr && REV_NEWER;
            end
            OFF_VECTOR: begin
                if (REV_NEWER) acc.bad    = rd || wr;
                else           acc.vec_rd = rd;
            end
            OFF_DMACFG: begin
                acc.dma_wr = wr;
                acc.dma_rd = rd;
            end
            OFF_TEST: begin
                acc.test_wr = wr;
                acc.test_rd = rd;
            end
            default: acc.bad = rd || wr;
        endcase
    end

endmodule

// File: rtl/isv_cfg.sv
module isv_cfg
    import isv_pkg::*;
#(
    parameter bit REV_NEWER = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  acc_t            acc,
    input  logic [DW-1:0]   wdata,
    output logic [NSRC-1:0] en_q,
    output logic [DW-1:0]   dma_q,
    output logic [DW-1:0]   test_q
);

    localparam int EN_BITS = REV_NEWER ? NSRC : NSRC - 1;
    localparam logic [NSRC-1:0] EN_KEEP = NSRC'((1 << EN_BITS) - 1);

    logic [NSRC-1:0] dma_strip;

    always_comb begin
        dma_strip = '1;
        if (wdata[DMA_RX_EN_BIT]) dma_strip[RX_RDY_BIT] = 1'b0;
        if (wdata[DMA_TX_EN_BIT]) dma_strip[TX_RDY_BIT] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            dma_q  <= '0;
            test_q <= '0;
        end else begin
            if (acc.en_wr)   en_q   <= wdata[NSRC-1:0] & EN_KEEP;
            if (acc.dma_wr) begin
                dma_q <= wdata & DMA_KEEP;
                en_q  <= en_q & dma_strip;
            end
            if (acc.test_wr) test_q <= wdata & TEST_KEEP;
        end
    end

    // R4: turning on receive DMA drops the receive-ready enable
    a_r4_dma_masks_rx: assert property (@(posedge clk) disable iff (rst)
        acc.dma_wr && wdata[DMA_RX_EN_BIT] |=> !en_q[RX_RDY_BIT]);

    // R4: turning on transmit DMA drops the transmit-ready enable
    a_r4_dma_masks_tx: assert property (@(posedge clk) disable iff (rst)
        acc.dma_wr && wdata[DMA_TX_EN_BIT] |=> !en_q[TX_RDY_BIT]);

endmodule

// File: rtl/isv_status.sv
module isv_status
    import isv_pkg::*;
#(
    parameter bit REV_NEWER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    flag_set,
    input  logic [DW-1:0]    flag_clr,
    input  logic [NSRC-1:0]  en_q,
    output logic [DW-1:0]    stat_q,
    output logic [VEC_W-1:0] vec
);

    logic [DW-1:0] vec_bit;
    logic [DW-1:0] clr_any;
    logic [DW-1:0] set_any;
    logic [DW-1:0] stat_nxt;

    assign vec     = lowest_pending(stat_q[NSRC-1:0] & en_q);
    assign vec_bit = (vec != '0) ? (DW'(1) << (vec - VEC_W'(1))) : '0;

    always_comb begin
        clr_any = flag_clr;
        if (acc.vec_rd)  clr_any = clr_any | vec_bit;
        if (acc.stat_wr) clr_any = clr_any | (wdata & W1C_MASK);
        set_any = flag_set;
        if (REV_NEWER && acc.test_wr && wdata[TEST_FORCE_BIT])
            set_any = set_any | FORCE_SET;
    end

    for (genvar b = 0; b < DW; b++) begin : g_flag
        if (STAT_STORE[b]) begin : g_kept
            assign stat_nxt[b] = (stat_q[b] & ~clr_any[b]) | set_any[b];
        end else begin : g_live
            assign stat_nxt[b] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_nxt;
    end

    // R2: a vector read acknowledges the reported source
    a_r2_vec_clears: assert property (@(posedge clk) disable iff (rst)
        acc.vec_rd && (vec != '0) && ((flag_set & vec_bit) == '0)
        |=> ((stat_q & $past(vec_bit)) == '0));

    // R10: a set pulse always lands
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        ((flag_set & STAT_STORE) != '0)
        |=> ((stat_q & $past(flag_set & STAT_STORE)) == $past(flag_set & STAT_STORE)));

    // R6: software cannot clear the ready flags in the newer model
    a_r6_ready_hold: assert property (@(posedge clk) disable iff (rst)
        REV_NEWER && ((flag_clr & RDY_BITS) == '0)
        |=> ((stat_q & $past(stat_q) & RDY_BITS) == ($past(stat_q) & RDY_BITS)));

endmodule

// File: rtl/intr_status_unit.sv
module intr_status_unit
    import isv_pkg::*;
#(
    parameter bit REV_NEWER = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    reg_sel,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [15:0]   reg_wdata,
    output logic [15:0]   reg_rdata,
    output logic          reg_err,
    input  logic [15:0]   flag_set,
    input  logic [15:0]   flag_clr,
    input  logic          bus_busy,
    output logic          irq,
    output logic          rx_dreq,
    output logic          tx_dreq
);

    acc_t             acc;
    logic [NSRC-1:0]  en_q;
    logic [DW-1:0]    dma_q;
    logic [DW-1:0]    test_q;
    logic [DW-1:0]    stat_q;
    logic [VEC_W-1:0] vec;
    logic [DW-1:0]    rd_val;
    logic [DW-1:0]    rdata_q;
    logic             err_q;

    isv_decode #(.REV_NEWER(REV_NEWER)) u_decode (
        .sel (reg_sel),
        .rd  (reg_rd),
        .wr  (reg_wr),
        .acc (acc)
    );

    isv_cfg #(.REV_NEWER(REV_NEWER)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .wdata  (reg_wdata),
        .en_q   (en_q),
        .dma_q  (dma_q),
        .test_q (test_q)
    );

    isv_status #(.REV_NEWER(REV_NEWER)) u_status (
        .clk      (clk),
        .rst      (rst),
        .acc      (acc),
        .wdata    (reg_wdata),
        .flag_set (flag_set),
        .flag_clr (flag_clr),
        .en_q     (en_q),
        .stat_q   (stat_q),
        .vec      (vec)
    );

    assign irq     = |(stat_q[NSRC-1:0] & en_q);
    assign rx_dreq = dma_q[DMA_RX_EN_BIT] & stat_q[RX_RDY_BIT];
    assign tx_dreq = dma_q[DMA_TX_EN_BIT] & stat_q[TX_RDY_BIT];

    always_comb begin
        rd_val = '0;
        if (acc.en_rd)   rd_val = DW'(en_q);
        if (acc.stat_rd) rd_val = stat_q | (DW'(bus_busy) << BUSY_BIT);
        if (acc.vec_rd)  rd_val = DW'(vec);
        if (acc.dma_rd)  rd_val = dma_q;
        if (acc.test_rd) rd_val = test_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= acc.bad;
            if (reg_rd) rdata_q <= rd_val;
        end
    end

    assign reg_rdata = rdata_q;
    assign reg_err   = err_q;

    // R11: an error pulse needs an access in the cycle before
    a_r11_err_needs_access: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd || reg_wr) |=> !reg_err);

    // R7: the vector offset is refused in the newer model
    a_r7_vector_refused: assert property (@(posedge clk) disable iff (rst)
        REV_NEWER && reg_rd && (reg_sel == 3'd2) |=> reg_err && (reg_rdata == '0));

    // R2: a vector read never reports beyond the source count
    a_r2_vec_range: assert property (@(posedge clk) disable iff (rst)
        !REV_NEWER && reg_rd && (reg_sel == 3'd2) |=> (reg_rdata <= 16'(NSRC)));

endmodule

// File: tb/intr_status_unit_tb.sv
module intr_status_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_sel = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] flag_set = '0;
    logic [15:0] flag_clr = '0;
    logic        bus_busy = 1'b0;

    logic [15:0] n_rdata, o_rdata;
    logic        n_err, o_err, n_irq, o_irq;
    logic        n_rxd, o_rxd, n_txd, o_txd;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    intr_status_unit #(.REV_NEWER(1'b1)) u_dut (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(n_rdata), .reg_err(n_err),
        .flag_set(flag_set), .flag_clr(flag_clr), .bus_busy(bus_busy),
        .irq(n_irq), .rx_dreq(n_rxd), .tx_dreq(n_txd));

    intr_status_unit #(.REV_NEWER(1'b0)) u_old (
        .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(o_rdata), .reg_err(o_err),
        .flag_set(flag_set), .flag_clr(flag_clr), .bus_busy(bus_busy),
        .irq(o_irq), .rx_dreq(o_rxd), .tx_dreq(o_txd));

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] off, input logic [15:0] d);
        @(negedge clk); reg_sel = off; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off);
        @(negedge clk); reg_sel = off; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] s, input logic [15:0] c);
        @(negedge clk); flag_set = s; flag_clr = c;
        @(negedge clk); flag_set = '0; flag_clr = '0;
    endtask

    task automatic t_reset;
        chk("R12 new irq", 16'(n_irq), 16'h0);
        chk("R12 old irq", 16'(o_irq), 16'h0);
        chk("R12 dreqs", {12'h0, n_rxd, n_txd, o_rxd, o_txd}, 16'h0);
        rd(3'd1);
        chk("R12 new status", n_rdata, 16'h0);
        rd(3'd0);
        chk("R12 old enable", o_rdata, 16'h0);
        rd(3'd3);
        chk("R12 new dma cfg", n_rdata, 16'h0);
        rd(3'd4);
        chk("R12 old test", o_rdata, 16'h0);
    endtask

    task automatic t_irq;
        wr(3'd0, 16'h003F);
        rd(3'd0);
        chk("R5 new enable width", n_rdata, 16'h003F);
        chk("R5 old enable width", o_rdata, 16'h001F);
        pulse(16'h0002, 16'h0);
        chk("R1 new irq on set", 16'(n_irq), 16'h1);
        chk("R1 old irq on set", 16'(o_irq), 16'h1);
        pulse(16'h0, 16'h0002);
        chk("R13 new irq after clear", 16'(n_irq), 16'h0);
        chk("R13 old irq after clear", 16'(o_irq), 16'h0);
        pulse(16'h0020, 16'h0);
        chk("R5 new bit5 irq", 16'(n_irq), 16'h1);
        chk("R5 old bit5 no irq", 16'(o_irq), 16'h0);
        pulse(16'h0, 16'hFFFF);
        pulse(16'h0004, 16'h0004);
        rd(3'd1);
        chk("R10 new set beats clear", n_rdata, 16'h0004);
        chk("R10 old set beats clear", o_rdata, 16'h0004);
        pulse(16'h0, 16'hFFFF);
    endtask

    task automatic t_vector;
        wr(3'd0, 16'h003F);
        pulse(16'h0012, 16'h0);
        rd(3'd2);
        chk("R2 old vector first", o_rdata, 16'h0002);
        chk("R2 old vector no err", 16'(o_err), 16'h0);
        chk("R7 new vector data", n_rdata, 16'h0);
        chk("R7 new vector err", 16'(n_err), 16'h1);
        rd(3'd1);
        chk("R2 old status after ack", o_rdata, 16'h0010);
        chk("R7 new status untouched", n_rdata, 16'h0012);
        rd(3'd2);
        chk("R2 old vector second", o_rdata, 16'h0005);
        rd(3'd2);
        chk("R2 old vector empty", o_rdata, 16'h0000);
        pulse(16'h0, 16'hFFFF);
        wr(3'd0, 16'h003C);
        pulse(16'h0009, 16'h0);
        rd(3'd2);
        chk("R2 old vector skips masked", o_rdata, 16'h0004);
        rd(3'd1);
        chk("R2 old masked bit kept", o_rdata, 16'h0001);
        pulse(16'h0, 16'hFFFF);
    endtask

    task automatic t_dma;
        wr(3'd0, 16'h003F);
        wr(3'd3, 16'hFFFF);
        rd(3'd3);
        chk("R4 new dma filter", n_rdata, 16'h8080);
        chk("R4 old dma filter", o_rdata, 16'h8080);
        rd(3'd0);
        chk("R4 new enable stripped", n_rdata, 16'h0027);
        chk("R4 old enable stripped", o_rdata, 16'h0007);
        pulse(16'h0018, 16'h0);
        chk("R3 new dreqs on", {14'h0, n_rxd, n_txd}, 16'h0003);
        chk("R3 old dreqs on", {14'h0, o_rxd, o_txd}, 16'h0003);
        chk("R1 new ready masked off", 16'(n_irq), 16'h0);
        wr(3'd3, 16'h0080);
        chk("R3 new rx gated off", {14'h0, n_rxd, n_txd}, 16'h0001);
        wr(3'd3, 16'h0000);
        chk("R3 old both gated off", {14'h0, o_rxd, o_txd}, 16'h0000);
        pulse(16'h0, 16'hFFFF);
    endtask

    task automatic t_w1c;
        pulse(16'h8C3F, 16'h0);
        wr(3'd1, 16'hFFFF);
        rd(3'd1);
        chk("R6 new write-one-clear", n_rdata, 16'h8C18);
        chk("R6 old status write ignored", o_rdata, 16'h8C3F);
        pulse(16'h0, 16'hFFFF);
    endtask

    task automatic t_busy;
        bus_busy = 1'b1;
        pulse(16'h1000, 16'h0);
        rd(3'd1);
        chk("R8 new busy live", n_rdata, 16'h1000);
        chk("R8 old busy live", o_rdata, 16'h1000);
        bus_busy = 1'b0;
        rd(3'd1);
        chk("R8 busy bit not stored", n_rdata, 16'h0000);
    endtask

    task automatic t_test;
        wr(3'd4, 16'hFFFF);
        rd(3'd4);
        chk("R9 new test filter", n_rdata, 16'hF80F);
        chk("R9 old test filter", o_rdata, 16'hF80F);
        rd(3'd1);
        chk("R9 new forced flags", n_rdata, 16'h003F);
        chk("R9 old no forcing", o_rdata, 16'h0000);
        wr(3'd4, 16'h0000);
        pulse(16'h0, 16'hFFFF);
    endtask

    task automatic t_invalid;
        wr(3'd0, 16'h0005);
        wr(3'd7, 16'hFFFF);
        chk("R11 write err pulse", 16'(n_err), 16'h1);
        rd(3'd0);
        chk("R11 enable untouched", n_rdata, 16'h0005);
        rd(3'd6);
        chk("R11 invalid read data", o_rdata, 16'h0000);
        chk("R11 invalid read err", 16'(o_err), 16'h1);
        @(negedge clk);
        chk("R11 err lasts one cycle", 16'(o_err), 16'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_irq();
        t_vector();
        t_dma();
        t_w1c();
        t_busy();
        t_test();
        t_invalid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule